// File: doc/BRIEF.md
# Phase Sequencer with Shared Call/Return Delay

This block is a small control state machine that walks through three working phases after a start request. The delay between phases is set from two 8-bit inputs. Every delay goes through one common wait state that acts like a subroutine. The calling phase writes the delay length into a single shared down-counter and writes the phase to resume into a return register. Then it jumps to the wait state. The wait state counts down and, when the delay has run out, jumps to whatever phase the return register holds.

The wait state must exit after a fixed time. To keep its exit decision shallow, it does not compare the full counter. Instead it watches a registered one-bit "last cycle" flag that is set one cycle ahead of time. The flag is also set when the counter is loaded, so a one-cycle delay works too. Once a wait has begun, it always runs to the end. A pulse on the done output marks that the sequence has finished.

Top module: `seq_wait_call`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the next state is idle, with `phase` = 0 and `done` = 0. The `phase` encoding is 0 idle, 1 phase A, 2 phase B, 3 phase C, 4 wait.
- R2: A high `start` sampled while idle moves the machine to phase A (`phase` = 1) on the next edge. When `start` is low, the machine stays idle.
- R3: Phase A and phase B each last exactly one cycle. Each is followed directly by the wait state (`phase` = 4).
- R4: A delay value N in the range 1 to 255 keeps the machine in the wait state for exactly N consecutive cycles.
- R5: A delay value of 0 gives the same wait as a value of 1, which is one cycle.
- R6: The wait called from phase A resumes in phase B. The wait called from phase B resumes in phase C. Phase C lasts one cycle and then returns to idle.
- R7: `done` is high for exactly the first idle cycle after phase C, and is low in every other cycle.
- R8: `delay_a` is sampled only in the phase A cycle, and `delay_b` only in the phase B cycle. Changing either input while a wait is running does not change the length of that wait.
- R9: A reset that arrives during a wait ends the wait, and the machine is idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sequence (acted on only when idle) |
| delay_a | input | 8 | Wait length after phase A, in cycles |
| delay_b | input | 8 | Wait length after phase B, in cycles |
| phase | output | 3 | Current state code |
| done | output | 1 | One-cycle pulse when the sequence ends |

## Verification
The hardest cases to reach are a wait whose early flag is set at load time rather than by counting, and a delay input that changes while its wait is running. The bench sweeps every pair of delays from 0 to 10, adds the 255 extremes, and compares the length of each phase cycle by cycle. Right after each call it writes unrelated values onto the delay input just consumed, so any late sampling would change the measured wait length. One run is cut short by a reset in the middle of a wait.

// File: rtl/seq_wait_call.sv
module seq_wait_call #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] delay_a,
  input  logic [DW-1:0] delay_b,
  output logic [2:0]    phase,
  output logic          done
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_A    = 3'd1,
    S_B    = 3'd2,
    S_C    = 3'd3,
    S_WAIT = 3'd4
  } st_t;

  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [DW-1:0] TWO = DW'(2);

  st_t           st, ret;
  logic [DW-1:0] cnt;
  logic          last;
  logic [DW-1:0] ld_raw, ld_val;
  logic          calling;

  assign calling = (st == S_A) || (st == S_B);
  assign ld_raw  = (st == S_A) ? delay_a : delay_b;
  assign ld_val  = (ld_raw == '0) ? ONE : ld_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      ret  <= S_IDLE;
      cnt  <= '0;
      last <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= (st == S_C);
      unique case (st)
        S_IDLE: if (start) st <= S_A;
        S_A, S_B: begin
          cnt  <= ld_val;
          last <= (ld_val == ONE);
          ret  <= (st == S_A) ? S_B : S_C;
          st   <= S_WAIT;
        end
        S_WAIT: begin
          cnt  <= cnt - ONE;
          last <= (cnt == TWO);
          if (last) st <= ret;
        end
        S_C: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign phase = st;

  p_reset_r1: assert property (@(posedge clk) rst |=> (st == S_IDLE && !done && cnt == '0));
  p_call_to_wait_r3: assert property (@(posedge clk) disable iff (rst)
    calling |=> (st == S_WAIT));
  p_hold_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && !last) |=> (st == S_WAIT));
  p_flag_at_one_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && last) |-> (cnt == ONE));
  p_return_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT) |-> (ret == S_B || ret == S_C));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: tb/tb_seq_wait_call.sv
module tb_seq_wait_call;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] delay_a = '0, delay_b = '0;
  logic [2:0] phase;
  logic done;
  int checks = 0, fails = 0;
  bit finished = 0;

  seq_wait_call dut (.clk(clk), .rst(rst), .start(start), .delay_a(delay_a),
                     .delay_b(delay_b), .phase(phase), .done(done));

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(int a, int b);
    int ea = (a == 0) ? 1 : a;
    int eb = (b == 0) ? 1 : b;
    delay_a = 8'(a); delay_b = 8'(b); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 enter A", phase, 1);
    @(negedge clk);
    delay_a = 8'(a ^ 8'h5A);  // R8: change after sampling
    for (int i = 0; i < ea; i++) begin
      chk((a == 0) ? "R5 wait A" : "R4 wait A", phase, 4);
      chk("R7 no done", done, 0);
      if (i == 0) begin @(negedge clk); delay_a = 8'(~a); end
      else @(negedge clk);
    end
    chk("R6 return B", phase, 2);
    @(negedge clk);
    delay_b = 8'(b ^ 8'hA5);  // R8
    for (int i = 0; i < eb; i++) begin
      chk((b == 0) ? "R5 wait B" : "R4 wait B", phase, 4);
      @(negedge clk);
    end
    chk("R6 return C", phase, 3);
    chk("R7 no done in C", done, 0);
    @(negedge clk);
    chk("R6 back idle", phase, 0);
    chk("R7 done pulse", done, 1);
    @(negedge clk);
    chk("R7 done ends", done, 0);
    chk("R2 stay idle", phase, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset phase", phase, 0);
    chk("R1 reset done", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 idle without start", phase, 0);
    for (int a = 0; a <= 10; a++)
      for (int b = 0; b <= 10; b++)
        run(a, b);
    run(255, 1);
    run(0, 255);
    run(255, 255);
    // R9: reset during a wait
    delay_a = 8'd20; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 in wait", phase, 4);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", phase, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 stays idle", phase, 0);
    run(3, 2);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule